// File: doc/BRIEF.md
# Two-Phase Address Mask ROM with Chained Select

This block is a read-only store of 1024 bytes that sits on a processor bus whose 16-bit address travels over eight shared lines in two steps. In the first step the processor puts the upper address byte on the lines and raises a strobe, and the block captures that byte in a holding register. In the second step the lines carry the lower byte, which the block uses directly. The six top bits of the held byte pick one 1K-word window of the 64K space. A parameter fixes which window this instance answers to.

When the window matches and the chip-enable input and both chip selects sit at their active levels, the block is selected. It then raises its chain-enable output so that a neighbouring memory can be gated from it. If the active-low read strobe is also low, the block places the addressed byte on a three-state bus. Each control input has its own polarity parameter. The stored contents come from a constant function of the word index. All outputs are registered and update one clock after the inputs that cause them.

Top module: `mux_addr_rom`

## Requirements
- R1: While `rst` is high at a rising clock edge, the held high byte is cleared, and `ce_out` and `bus_oe` are 0 after that edge.
- R2: At a rising edge where the strobe is at its active level (high by default), the held high byte takes the value of `addr_lines`. At any other edge it keeps its value, so changing only the low byte never alters it.
- R3: One clock after an edge, `ce_out` is 1 exactly when held bits [7:2] equal `BLOCK_BASE` (default 6'h05) and `ce_in`, `cs_a` and `cs_b` are all at their active levels. The defaults are `ce_in` active high, `cs_a` active low and `cs_b` active high.
- R4: The word index is {held bits [1:0], `addr_lines`}. Word i holds SEED ^ i[7:0] ^ {6'b0, i[9:8]}, with SEED defaulting to 8'h5A, and it appears on `bus_io` one clock after the read edge.
- R5: `bus_oe` is 1 one clock after an edge only if the block was selected at that edge and `rd_n` was 0. Otherwise `bus_oe` is 0 and `bus_io` floats.
- R6: If any single enable or select input is at its inactive level, the block is deselected: `ce_out` is 0 and `bus_oe` is 0.
- R7: A held high byte that points outside the configured window, including the adjacent windows just below and just above it, leaves the block deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_lines | input | 8 | Shared address lines: high byte during the strobe, low byte afterwards |
| hi_stb | input | 1 | High-address capture strobe, polarity set by parameter |
| rd_n | input | 1 | Active-low read strobe |
| ce_in | input | 1 | Chip-enable input from the chain |
| cs_a | input | 1 | Chip select A |
| cs_b | input | 1 | Chip select B |
| ce_out | output | 1 | High while the block is selected, for chaining |
| bus_oe | output | 1 | High while the block drives the data bus |
| bus_io | inout | 8 | Three-state data bus |

## Verification
The hardest case to reach is a read whose high byte was captured several transactions earlier. Between the capture and the read, the low lines have carried unrelated values and the strobe has sat inactive. The stimulus captures a window byte once and then issues a run of reads, control toggles and low-byte changes with no new strobe. It also pulses the lines to a foreign value while the strobe is at its inactive level. Later reads must still land in the first captured window, which shows that the held byte never moved. Bytes just below and just above the window are captured as well, to show that the window compare is exact.

// File: rtl/mux_addr_rom_pkg.sv
package mux_addr_rom_pkg;

  // level of a control pin compared with its configured active level
  function automatic logic pin_active(input logic level, input bit act_high);
    return (level == act_high);
  endfunction

endpackage

// File: rtl/hi_addr_latch.sv
module hi_addr_latch #(
  parameter int  LINE_W  = 8,
  parameter bit  STB_POL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] lines,
  input  logic              stb,
  output logic [LINE_W-1:0] hi_q
);
  import mux_addr_rom_pkg::*;

  logic stb_on;
  assign stb_on = pin_active(stb, STB_POL);

  always_ff @(posedge clk) begin
    if (rst)         hi_q <= '0;
    else if (stb_on) hi_q <= lines;
  end

  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (stb == STB_POL) |=> (hi_q == $past(lines)));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (stb != STB_POL) |=> $stable(hi_q));

endmodule

// File: rtl/window_select.sv
module window_select #(
  parameter int          HI_W     = 8,
  parameter int          BASE_W   = 6,
  parameter [BASE_W-1:0] BASE     = '0,
  parameter bit          CE_POL   = 1'b1,
  parameter bit          CSA_POL  = 1'b0,
  parameter bit          CSB_POL  = 1'b1
) (
  input  logic [HI_W-1:0] hi_q,
  input  logic            ce_in,
  input  logic            cs_a,
  input  logic            cs_b,
  output logic            hit
);
  import mux_addr_rom_pkg::*;

  localparam int NCTL = 3;

  logic [NCTL-1:0] ctl_lvl;
  logic [NCTL-1:0] ctl_on;
  localparam bit [NCTL-1:0] CTL_POL = {CSB_POL, CSA_POL, CE_POL};

  assign ctl_lvl = {cs_b, cs_a, ce_in};

  for (genvar g = 0; g < NCTL; g++) begin : g_ctl
    assign ctl_on[g] = pin_active(ctl_lvl[g], CTL_POL[g]);
  end

  logic win_match;
  assign win_match = (hi_q[HI_W-1 -: BASE_W] == BASE);
  assign hit       = win_match & (&ctl_on);

endmodule

// File: rtl/rom_core.sv
module rom_core #(
  parameter int          WORD_AW = 10,
  parameter int          DATA_W  = 8,
  parameter [DATA_W-1:0] SEED    = 8'h5A
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WORD_AW-1:0] idx,
  output logic [DATA_W-1:0]  word_q
);

  // fold every index bit onto data bit (b mod DATA_W), then mix in the seed
  function automatic logic [DATA_W-1:0] rom_word(input logic [WORD_AW-1:0] i);
    logic [DATA_W-1:0] w;
    w = SEED;
    for (int b = 0; b < WORD_AW; b++) w[b % DATA_W] = w[b % DATA_W] ^ i[b];
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= rom_word(idx);
  end

endmodule

// File: rtl/mux_addr_rom.sv
module mux_addr_rom #(
  parameter int  ADDR_W     = 16,
  parameter int  LINE_W     = 8,
  parameter int  DATA_W     = 8,
  parameter int  WORD_AW    = 10,
  parameter int  BLOCK_BASE = 5,
  parameter int  SEED       = 8'h5A,
  parameter bit  STB_POL    = 1'b1,
  parameter bit  CE_POL     = 1'b1,
  parameter bit  CSA_POL    = 1'b0,
  parameter bit  CSB_POL    = 1'b1
) (
  input  wire logic              clk,
  input  wire logic              rst,
  input  wire logic [LINE_W-1:0] addr_lines,
  input  wire logic              hi_stb,
  input  wire logic              rd_n,
  input  wire logic              ce_in,
  input  wire logic              cs_a,
  input  wire logic              cs_b,
  output logic                   ce_out,
  output logic                   bus_oe,
  inout  wire [DATA_W-1:0]       bus_io
);

  localparam int HI_W     = ADDR_W - LINE_W;
  localparam int BASE_W   = ADDR_W - WORD_AW;
  localparam int IDX_HI_W = WORD_AW - LINE_W;
  localparam logic [BASE_W-1:0] BASE_V = BASE_W'(BLOCK_BASE);
  localparam logic [DATA_W-1:0] SEED_V = DATA_W'(SEED);

  logic [HI_W-1:0]    hi_q;
  logic               hit;
  logic [WORD_AW-1:0] idx;
  logic [DATA_W-1:0]  word_q;

  hi_addr_latch #(.LINE_W(LINE_W), .STB_POL(STB_POL)) u_latch (
    .clk(clk), .rst(rst), .lines(addr_lines), .stb(hi_stb), .hi_q(hi_q)
  );

  window_select #(
    .HI_W(HI_W), .BASE_W(BASE_W), .BASE(BASE_V),
    .CE_POL(CE_POL), .CSA_POL(CSA_POL), .CSB_POL(CSB_POL)
  ) u_sel (
    .hi_q(hi_q), .ce_in(ce_in), .cs_a(cs_a), .cs_b(cs_b), .hit(hit)
  );

  assign idx = {hi_q[IDX_HI_W-1:0], addr_lines};

  rom_core #(.WORD_AW(WORD_AW), .DATA_W(DATA_W), .SEED(SEED_V)) u_rom (
    .clk(clk), .rst(rst), .idx(idx), .word_q(word_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_out <= 1'b0;
      bus_oe <= 1'b0;
    end else begin
      ce_out <= hit;
      bus_oe <= hit & ~rd_n;
    end
  end

  assign bus_io = bus_oe ? word_q : {DATA_W{1'bz}};

  a_r5_oe_needs_sel: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> ce_out);
  a_r5_oe_needs_rd: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> $past(!rd_n));
  a_r3_window: assert property (@(posedge clk) disable iff (rst)
    $rose(ce_out) |-> ($past(hi_q[HI_W-1 -: BASE_W]) == BASE_V));
  a_r6_enables: assert property (@(posedge clk) disable iff (rst)
    (ce_in != CE_POL) |=> !ce_out);

endmodule

// File: tb/mux_addr_rom_bench.sv
module mux_addr_rom_bench;

  localparam logic [5:0] BASE = 6'h05;
  localparam logic [7:0] SEED = 8'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] addr_lines = '0;
  logic hi_stb = 1'b0, rd_n = 1'b1, ce_in = 1'b0, cs_a = 1'b1, cs_b = 1'b0;
  logic ce_out, bus_oe;
  wire  [7:0] bus_io;

  always #10 clk = ~clk;

  mux_addr_rom u_mux_addr_rom (
    .clk(clk), .rst(rst), .addr_lines(addr_lines), .hi_stb(hi_stb),
    .rd_n(rd_n), .ce_in(ce_in), .cs_a(cs_a), .cs_b(cs_b),
    .ce_out(ce_out), .bus_oe(bus_oe), .bus_io(bus_io)
  );

  typedef struct {
    logic       sel;
    logic       oe;
    logic [7:0] data;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  logic [7:0] m_hi = '0;
  bit   done = 0, reported = 0;

  function automatic logic [7:0] word_of(input logic [9:0] i);
    return SEED ^ i[7:0] ^ {6'b0, i[9:8]};
  endfunction

  task automatic drive(input logic r, input logic stb, input logic [7:0] ln,
                       input logic rd, input logic ce, input logic ca,
                       input logic cb, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; hi_stb = stb; addr_lines = ln; rd_n = rd;
    ce_in = ce; cs_a = ca; cs_b = cb;
    if (r) begin
      e.sel = 0; e.oe = 0; e.data = 0;
      m_hi = '0;
    end else begin
      e.sel  = (m_hi[7:2] == BASE) && ce && !ca && cb;
      e.oe   = e.sel && !rd;
      e.data = word_of({m_hi[1:0], ln});
      if (stb) m_hi = ln;
    end
    e.tag = tag;
    q.push_back(e);
  endtask

  // read with all controls active
  task automatic rd_at(input logic [7:0] lo, input string tag);
    drive(0, 0, lo, 0, 1, 0, 1, tag);
  endtask

  task automatic cap(input logic [7:0] hi, input string tag);
    drive(0, 1, hi, 1, 0, 1, 0, tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        bit bad;
        e = q.pop_front();
        n_chk++;
        bad = (ce_out !== e.sel) || (bus_oe !== e.oe) ||
              (e.oe && (bus_io !== e.data));
        if (bad) begin
          n_fail++;
          $display("FAIL %s: ce_out=%0b oe=%0b bus=%02h expected ce_out=%0b oe=%0b bus=%02h",
                   e.tag, ce_out, bus_oe, bus_io, e.sel, e.oe, e.data);
        end
      end
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
    end
  end

  initial begin : stim
    for (int k = 0; k < 3; k++) drive(1, 1, 8'hFF, 0, 1, 0, 1, "R1 reset");
    rd_at(8'h10, "R1 latch cleared so unselected");
    cap(8'h15, "R2 capture window byte");
    rd_at(8'h00, "R4 read low 00");
    rd_at(8'h7F, "R4 read low 7F");
    rd_at(8'hFF, "R4 read low FF");
    drive(0, 0, 8'h33, 1, 1, 0, 1, "R5 selected without read");
    drive(0, 0, 8'h33, 0, 0, 0, 1, "R6 ce_in inactive");
    drive(0, 0, 8'h33, 0, 1, 1, 1, "R6 cs_a inactive");
    drive(0, 0, 8'h33, 0, 1, 0, 0, "R6 cs_b inactive");
    drive(0, 0, 8'h00, 1, 0, 1, 0, "R2 inactive strobe level, foreign lines");
    drive(0, 0, 8'h19, 1, 0, 1, 0, "R2 low byte only change");
    rd_at(8'h42, "R2 held byte unchanged");
    cap(8'h13, "R7 capture window below");
    rd_at(8'h42, "R7 window below unselected");
    cap(8'h18, "R7 capture window above");
    rd_at(8'h42, "R7 window above unselected");
    cap(8'h17, "R4 capture top quarter");
    rd_at(8'h80, "R4 index 0x380");
    rd_at(8'h01, "R4 index 0x301");
    drive(0, 0, 8'h01, 1, 1, 0, 1, "R5 read released");
    cap(8'h14, "R2 recapture");
    rd_at(8'hC3, "R4 index 0x0C3");
    drive(0, 0, 8'h00, 1, 0, 1, 0, "R5 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    report();
  end

endmodule